// File: doc/BRIEF.md
# Size-Aware Shift and Rotate Unit

This block is the combinational shift and rotate stage for register micro-operations. It takes a source value, a count operand and the current carry flag. It shifts or rotates the low 1, 2, 4 or 8 bytes of the source. The result goes into the same low bytes of the incoming destination value, and the bytes above them keep their old contents. The count comes either from the low byte of a register operand or from an 8-bit immediate.

There are seven operations: logical left, logical right and arithmetic right shift, plain rotate left and right within the operand width, and rotate left and right through the carry bit. The carry flag is an input only. Flag generation, instruction decode and register storage sit outside the block.

Top module: `shrot_unit`

## Requirements
- R1: The count is the low byte of `cntReg` when `useImm` is 0 and `cntImm` when it is 1. It is masked to its low 6 bits when `sizeSel` is 3 (8 bytes) and to its low 5 bits for `sizeSel` 0, 1, 2 (1, 2, 4 bytes). Higher count bits have no effect.
- R2: With `opSel` 0 (logical left), result bit i equals source bit i−n for i ≥ n and 0 below, where n is the masked count. A count of at least the operand width gives zero.
- R3: With `opSel` 1 (logical right), the vacated upper bits within the operand width are zero. A count of at least the width gives zero.
- R4: With `opSel` 2 (arithmetic right), the vacated upper bits copy the source's sign bit at the selected size. A count of at least the width gives all sign bits.
- R5: With `opSel` 3 (rotate right) and `opSel` 4 (rotate left), bits wrap within the operand width, and the count is taken modulo the width.
- R6: With `opSel` 5 (rotate right through carry), the operand and the carry form a ring of width+1 bits with the carry above the top bit. The ring turns right by the count modulo width+1, and the low width bits are the result.
- R7: With `opSel` 6 (rotate left through carry), the same width+1 ring turns left by the count modulo width+1. For a count of 1 to width, the old carry lands at bit count−1.
- R8: For the four rotates (`opSel` 3 to 6), a masked count of zero returns the destination value unchanged in all 64 bits.
- R9: Otherwise, bits at and above 8·2^`sizeSel` equal the destination's bits. A shift by zero copies the source's low bytes into the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcVal | input | 64 | Value to shift or rotate |
| destVal | input | 64 | Current destination register value |
| cntReg | input | 64 | Register count operand (low byte used) |
| cntImm | input | 8 | Immediate count operand |
| useImm | input | 1 | 1 selects the immediate count |
| sizeSel | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| opSel | input | 3 | Operation code, see R2 to R7 |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 64 | Merged destination value |

## Verification
The bench sweeps every operation, size and count from 0 to 63 through both count sources. High count bits are set on every count so that a wrong mask shows up. A unit that masked 8-bit and 16-bit counts with 6 bits, or that rotated modulo the register instead of the operand, would return wrong low bytes for counts above the width. The through-carry rotates are compared against a one-step ring model, which exposes an off-by-one in the carry position or a reduction modulo width instead of width+1. A zero-count rotate that merged the source instead of holding the destination, or a merge that disturbed the upper bytes, would break the full 64-bit comparison.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int XLEN   = 64;
  localparam int AMT_W  = $clog2(XLEN) + 1;   // holds XLEN and XLEN+1
  localparam int RING_W = 2 * XLEN + 2;       // room for a width+1 ring shifted by up to width+1

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4,
    OP_RCR = 3'd5,
    OP_RCL = 3'd6,
    OP_RSV = 3'd7
  } shOp_e;

  typedef struct packed {
    logic             rotate;
    logic             rightDir;
    logic             thruCarry;
    logic             arith;
    logic             saturate;
    logic             holdDest;
    logic [AMT_W-1:0] amt;
    logic [AMT_W-1:0] width;
  } ctlStrobes_t;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [XLEN-1:0] cntReg,
  input  logic [7:0]      cntImm,
  input  logic            useImm,
  input  logic [1:0]      sizeSel,
  input  shOp_e           opSel,
  output ctlStrobes_t     strobes
);
  logic [7:0]       rawCnt;
  logic [5:0]       maskedCnt;
  logic [AMT_W-1:0] opWidth;
  logic [AMT_W-1:0] ringLen;
  logic [AMT_W-1:0] modAmt;

  always_comb begin
    rawCnt    = useImm ? cntImm : cntReg[7:0];
    maskedCnt = (sizeSel == 2'd3) ? rawCnt[5:0] : {1'b0, rawCnt[4:0]};
    opWidth   = AMT_W'(8) << sizeSel;
    ringLen   = opWidth + AMT_W'(1);

    // reduce modulo width+1 for the through-carry ring (count < 64 needs at most 3 steps)
    modAmt = AMT_W'(maskedCnt);
    for (int k = 0; k < 4; k++) begin
      if (modAmt >= ringLen) modAmt = modAmt - ringLen;
    end

    strobes           = '0;
    strobes.width     = opWidth;
    strobes.amt       = AMT_W'(maskedCnt);
    case (opSel)
      OP_SHR: strobes.rightDir = 1'b1;
      OP_SAR: begin strobes.rightDir = 1'b1; strobes.arith = 1'b1; end
      OP_ROR: begin strobes.rotate = 1'b1; strobes.rightDir = 1'b1; end
      OP_ROL: strobes.rotate = 1'b1;
      OP_RCR: begin strobes.rotate = 1'b1; strobes.rightDir = 1'b1; strobes.thruCarry = 1'b1; end
      OP_RCL: begin strobes.rotate = 1'b1; strobes.thruCarry = 1'b1; end
      default: ;
    endcase
    if (strobes.rotate) begin
      strobes.amt = strobes.thruCarry ? modAmt : (AMT_W'(maskedCnt) & (opWidth - AMT_W'(1)));
    end
    strobes.saturate = !strobes.rotate && (AMT_W'(maskedCnt) >= opWidth);
    strobes.holdDest = strobes.rotate && (maskedCnt == 6'd0);
  end

  // rotate amounts handed to the datapath stay inside the ring
  always_comb begin
    if (strobes.rotate) begin
      p_amt_range_r5: assert (strobes.amt < strobes.width + AMT_W'(strobes.thruCarry))
        else $error("rotate amount %0d out of range", strobes.amt);
    end
  end
endmodule

// File: rtl/shrot_dpath.sv
module shrot_dpath
  import shrot_pkg::*;
(
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN-1:0] destVal,
  input  logic            carryIn,
  input  ctlStrobes_t     strobes,
  output logic [XLEN-1:0] resultOut
);
  logic [XLEN:0]     wideMask;
  logic [XLEN-1:0]   wMask;
  logic [XLEN-1:0]   srcW;
  logic [XLEN-1:0]   fillMask;
  logic [XLEN-1:0]   opRes;
  logic [5:0]        topIdx;
  logic              signBit;
  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] ringRot;
  logic [RING_W-1:0] ringMask;
  logic [AMT_W-1:0]  backAmt;

  always_comb begin
    wideMask = ((XLEN+1)'(1) << strobes.width) - (XLEN+1)'(1);
    wMask    = wideMask[XLEN-1:0];
    ringMask = (RING_W'(wideMask) << 1) | RING_W'(1);
    srcW     = srcVal & wMask;
    topIdx   = 6'(strobes.width - AMT_W'(1));
    signBit  = srcVal[topIdx];
    fillMask = wMask & ~(wMask >> strobes.amt);

    ring    = RING_W'(srcW);
    backAmt = strobes.width - strobes.amt;
    if (strobes.thruCarry) begin
      ring    = ring | ((RING_W'(carryIn)) << strobes.width);
      backAmt = backAmt + AMT_W'(1);
    end

    ringRot = '0;
    if (strobes.rightDir) ringRot = (ring >> strobes.amt) | (ring << backAmt);
    else                  ringRot = (ring << strobes.amt) | (ring >> backAmt);

    if (strobes.rotate) begin
      opRes = ringRot[XLEN-1:0] & wMask;
    end else if (strobes.saturate) begin
      opRes = (strobes.arith && signBit) ? wMask : '0;
    end else if (strobes.rightDir) begin
      opRes = (srcW >> strobes.amt) | ((strobes.arith && signBit) ? fillMask : '0);
    end else begin
      opRes = (srcW << strobes.amt) & wMask;
    end

    resultOut = strobes.holdDest ? destVal : ((destVal & ~wMask) | opRes);
  end

  always_comb begin
    if (strobes.rotate && !strobes.thruCarry) begin
      p_rot_bits_kept_r5: assert ($countones(opRes) == $countones(srcW))
        else $error("plain rotate changed the bit count");
    end
    if (strobes.rotate && strobes.thruCarry) begin
      p_ring_bits_kept_r6: assert ($countones(ringRot & ringMask) == $countones(ring))
        else $error("carry ring changed the bit count");
    end
    if (!strobes.rotate && strobes.rightDir && !strobes.arith && !strobes.saturate
        && strobes.amt != '0) begin
      p_shr_zero_fill_r3: assert ((opRes >> backAmt) == '0)
        else $error("logical right shift filled with ones");
    end
    if (!strobes.rotate && strobes.arith && signBit && strobes.amt != '0) begin
      p_sar_sign_fill_r4: assert ((opRes & fillMask) == fillMask)
        else $error("arithmetic right shift lost the sign");
    end
    if (!strobes.holdDest) begin
      p_upper_kept_r9: assert ((resultOut & ~wMask) == (destVal & ~wMask))
        else $error("upper destination bits disturbed");
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic [63:0] srcVal,
  input  logic [63:0] destVal,
  input  logic [63:0] cntReg,
  input  logic [7:0]  cntImm,
  input  logic        useImm,
  input  logic [1:0]  sizeSel,
  input  logic [2:0]  opSel,
  input  logic        carryIn,
  output logic [63:0] resultOut
);
  ctlStrobes_t strobes;

  shrot_ctrl u_ctrl (
    .cntReg  (cntReg),
    .cntImm  (cntImm),
    .useImm  (useImm),
    .sizeSel (sizeSel),
    .opSel   (shOp_e'(opSel)),
    .strobes (strobes)
  );

  shrot_dpath u_dpath (
    .srcVal    (srcVal),
    .destVal   (destVal),
    .carryIn   (carryIn),
    .strobes   (strobes),
    .resultOut (resultOut)
  );
endmodule

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;
  logic        clk = 1'b0;
  logic [63:0] srcVal, destVal, cntReg, resultOut;
  logic [7:0]  cntImm;
  logic        useImm, carryIn;
  logic [1:0]  sizeSel;
  logic [2:0]  opSel;
  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shrot_unit uut (
    .srcVal(srcVal), .destVal(destVal), .cntReg(cntReg), .cntImm(cntImm),
    .useImm(useImm), .sizeSel(sizeSel), .opSel(opSel), .carryIn(carryIn),
    .resultOut(resultOut)
  );

  function automatic logic [63:0] model(int op, int sz, logic [7:0] c,
                                        logic [63:0] s, logic [63:0] d, logic cf);
    int w = 8 << sz;
    int m = (sz == 3) ? int'(c[5:0]) : int'(c[4:0]);
    logic [63:0] r = '0;
    logic [64:0] rg = '0;
    logic [63:0] res = '0;
    logic t;
    if (op >= 3 && m == 0) return d;
    case (op)
      0: for (int i = 0; i < w; i++) r[i] = (i >= m) ? s[i-m] : 1'b0;
      1: for (int i = 0; i < w; i++) r[i] = (i + m < w) ? s[i+m] : 1'b0;
      2: for (int i = 0; i < w; i++) r[i] = (i + m < w) ? s[i+m] : s[w-1];
      3: for (int i = 0; i < w; i++) r[i] = s[(i + m) % w];
      4: for (int i = 0; i < w; i++) r[i] = s[((i - (m % w)) + w) % w];
      default: begin
        for (int i = 0; i < w; i++) rg[i] = s[i];
        rg[w] = cf;
        for (int k = 0; k < m; k++) begin
          if (op == 5) begin
            t = rg[0];
            for (int i = 0; i < w; i++) rg[i] = rg[i+1];
            rg[w] = t;
          end else begin
            t = rg[w];
            for (int i = w; i > 0; i--) rg[i] = rg[i-1];
            rg[0] = t;
          end
        end
        for (int i = 0; i < w; i++) r[i] = rg[i];
      end
    endcase
    for (int i = 0; i < 64; i++) res[i] = (i < w) ? r[i] : d[i];
    return res;
  endfunction

  function automatic string tagFor(int op, int m);
    if (op >= 3 && m == 0) return "R8";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] exp);
    #2;
    total++;
    if (resultOut !== exp) begin
      bad++;
      $display("FAIL %s op=%0d size=%0d useImm=%0d cnt=%0d act=%h exp=%h",
               tag, opSel, sizeSel, useImm, useImm ? cntImm : cntReg[7:0], resultOut, exp);
    end
    #2;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] srcs [2];
    logic [63:0] dsts [2];
    logic [7:0]  c;
    int          m;
    srcs[0] = 64'h8F3C_5A17_E2D9_0B64;
    srcs[1] = 64'h71C4_9A2E_F305_B6D8;
    dsts[0] = 64'h0123_4567_89AB_CDEF;
    dsts[1] = 64'hFEDC_BA98_7654_3210;

    // idle state: all-zero inputs give zero (R9)
    srcVal = '0; destVal = '0; cntReg = '0; cntImm = '0;
    useImm = 1'b0; sizeSel = 2'd0; opSel = 3'd0; carryIn = 1'b0;
    check("R9", 64'd0);

    // shift by zero copies source low bytes into destination (R9)
    srcVal = srcs[0]; destVal = dsts[0]; sizeSel = 2'd1; opSel = 3'd0;
    check("R9", 64'h0123_4567_89AB_0B64);

    for (int op = 0; op < 7; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int pat = 0; pat < 2; pat++) begin
          for (int cnt = 0; cnt < 64; cnt++) begin
            opSel = 3'(op); sizeSel = 2'(sz);
            srcVal = srcs[pat]; destVal = dsts[pat];
            carryIn = pat[0] ^ cnt[0];
            // register count: high bits of the low byte set, must be ignored (R1)
            c = 8'(cnt) | 8'hC0;
            m = (sz == 3) ? int'(c[5:0]) : int'(c[4:0]);
            useImm = 1'b0; cntReg = 64'hA5A5_5A5A_0000_0000 | 64'(c); cntImm = 8'h3F;
            check(tagFor(op, m), model(op, sz, c, srcVal, destVal, carryIn));
            // immediate count path with a conflicting register operand (R1)
            c = 8'(cnt) | 8'h80;
            useImm = 1'b1; cntImm = c; cntReg = 64'h0000_0000_0000_0017;
            check("R1", model(op, sz, c, srcVal, destVal, carryIn));
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule